// File: doc/BRIEF.md
# Byte-Addressed SRAM Controller with Posted Write

This block connects a simple request/response bus to a synchronous on-chip memory array whose capacity is a parameter (2, 4 or 8 kB). Byte, halfword and word accesses are supported. Addresses are byte addresses. Each access is forced onto its natural boundary by ignoring the low address bits, and the block derives the byte-lane enables from the access size and offset.

Writes never stall. A one-entry posted buffer takes each write in the cycle it is offered. The entry it held until then is written into the array in that same cycle. Idle cycles and reads never drain the buffer, and reset empties it without a commit. Software that needs a value to survive reset must therefore follow it with another write, such as a repeat of the same write.

A read reaches the array in the cycle it is accepted. The response appears one cycle later. When the read's word matches the buffered entry, the pending bytes are merged over the array data.

The request side uses valid/ready, but `req_ready` is held high, so the requester never sees back-pressure. The response side has no ready: `rsp_valid` is a one-cycle pulse and must be taken when it appears.

Top module: `sram_posted_ctrl`

## Requirements
- R1: `req_ready` is 1 in every cycle. Every cycle with `req_valid` high is one accepted access, and back-to-back writes are each accepted in their own cycle.
- R2: `req_size` encodes 0 as byte, 1 as halfword and 2 as word (3 behaves as word). A word access ignores `req_addr[1:0]` and a halfword access ignores `req_addr[0]`.
- R3: Lanes are little-endian. A byte at offset n uses bits 8n+7..8n. A halfword uses the low half when `req_addr[1]`=0 and the high half otherwise. A word uses all four lanes, and only the enabled lanes of the word change.
- R4: A byte write stores `req_wdata[7:0]` and a halfword write stores `req_wdata[15:0]`. The remaining data bits have no effect.
- R5: `buf_valid` is 0 after reset, becomes 1 after the first accepted write, and stays 1 until the next reset.
- R6: The buffered entry is written to the array only in a cycle where a new write is accepted. `commit_pulse` is high in exactly those cycles in which the buffer was valid. Reads and idle cycles never commit.
- R7: Reset empties the buffer without committing it, so the array does not contain the last write made before reset.
- R8: Two identical consecutive writes to one location leave that data in the array across a reset.
- R9: `rsp_valid` is high for exactly the one cycle after each accepted read. Byte and halfword read data is zero-extended from bit 0.
- R10: A read of the buffered word returns the buffered bytes for the lanes the buffer covers and the array bytes for the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | AW | Byte address, AW = log2(MEM_BYTES) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data, zero-extended |
| buf_valid | output | 1 | Posted buffer holds an entry |
| commit_pulse | output | 1 | Array write occurring this cycle |

## Verification
The bench aims at the cycle in which a write commits. A design that drains on idle would let data survive reset, and one that commits on the wrong edge would lose the older write.

It reads back words that are part pending and part committed. A design with a wrong merge mask, a wrong lane order or a wrong comparison of the buffered address would return stale or shifted bytes.

Misaligned halfword and word addresses, and junk in the upper write-data bits, expose a design that does not mask the low address bits or does not replicate the data across lanes.

Reset tests show that the last write is lost, and that a repeated write is kept.

// File: rtl/sram_pw_pkg.sv
package sram_pw_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned DW    = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/spw_lane_decode.sv
module spw_lane_decode
  import sram_pw_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [1:0]       ofs,
  input  logic [DW-1:0]    wdata,
  output logic [LANES-1:0] lane_en,
  output logic [DW-1:0]    wdata_rep
);
  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: begin
        lane_en   = 4'b0001 << ofs;
        wdata_rep = {4{wdata[7:0]}};
      end
      SZ_HALF: begin
        lane_en   = ofs[1] ? 4'b1100 : 4'b0011;
        wdata_rep = {2{wdata[15:0]}};
      end
      default: begin
        lane_en   = 4'b1111;
        wdata_rep = wdata;
      end
    endcase
  end
endmodule

// File: rtl/spw_post_buffer.sv
module spw_post_buffer
  import sram_pw_pkg::*;
#(
  parameter int unsigned WIDX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic [WIDX-1:0]  wr_word,
  input  logic [LANES-1:0] wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic             valid,
  output logic [WIDX-1:0]  buf_word,
  output logic [LANES-1:0] buf_en,
  output logic [DW-1:0]    buf_data,
  output logic             commit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      buf_word <= '0;
      buf_en   <= '0;
      buf_data <= '0;
    end else if (wr_accept) begin
      valid    <= 1'b1;
      buf_word <= wr_word;
      buf_en   <= wr_en;
      buf_data <= wr_data;
    end
  end

  assign commit = wr_accept & valid;

  AST_BUF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid); // R5
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> $stable(buf_data) && $stable(buf_word) && $stable(buf_en)); // R6
endmodule

// File: rtl/spw_array.sv
module spw_array
  import sram_pw_pkg::*;
#(
  parameter int unsigned WORDS = 512,
  parameter int unsigned WIDX  = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [WIDX-1:0]  waddr,
  input  logic [LANES-1:0] wen,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [WIDX-1:0]  raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [WORDS];
    always_ff @(posedge clk) begin
      if (we && wen[g]) cells[waddr] <= wdata[8*g +: 8];
      if (re) rdata[8*g +: 8] <= cells[raddr];
    end
  end
endmodule

// File: rtl/spw_read_merge.sv
module spw_read_merge
  import sram_pw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_accept,
  input  logic [1:0]       rd_size,
  input  logic [1:0]       rd_ofs,
  input  logic             hit,
  input  logic [LANES-1:0] buf_en,
  input  logic [DW-1:0]    buf_data,
  input  logic [DW-1:0]    arr_rdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata
);
  logic [1:0]       size_q;
  logic [1:0]       ofs_q;
  logic [LANES-1:0] fwd_en_q;
  logic [DW-1:0]    fwd_data_q;
  logic [DW-1:0]    merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      size_q     <= '0;
      ofs_q      <= '0;
      fwd_en_q   <= '0;
      fwd_data_q <= '0;
    end else begin
      rsp_valid <= rd_accept;
      if (rd_accept) begin
        size_q     <= rd_size;
        ofs_q      <= rd_ofs;
        fwd_en_q   <= hit ? buf_en : '0;
        fwd_data_q <= buf_data;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mrg
    assign merged[8*g +: 8] = fwd_en_q[g] ? fwd_data_q[8*g +: 8] : arr_rdata[8*g +: 8];
  end

  always_comb begin
    case (acc_size_e'(size_q))
      SZ_BYTE: rsp_rdata = {24'd0, merged[8*ofs_q +: 8]};
      SZ_HALF: rsp_rdata = {16'd0, ofs_q[1] ? merged[31:16] : merged[15:0]};
      default: rsp_rdata = merged;
    endcase
  end
endmodule

// File: rtl/sram_posted_ctrl.sv
module sram_posted_ctrl
  import sram_pw_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 2048,
  localparam int unsigned AW    = $clog2(MEM_BYTES),
  localparam int unsigned WORDS = MEM_BYTES / LANES,
  localparam int unsigned WIDX  = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          buf_valid,
  output logic          commit_pulse
);
  logic             acc, wr_acc, rd_acc, hit;
  logic [WIDX-1:0]  word_idx, buf_word;
  logic [LANES-1:0] lane_en, buf_en;
  logic [DW-1:0]    wdata_rep, buf_data, arr_rdata;

  assign req_ready = 1'b1;
  assign acc       = req_valid & req_ready;
  assign wr_acc    = acc & req_write;
  assign rd_acc    = acc & ~req_write;
  assign word_idx  = req_addr[AW-1:2];
  assign hit       = buf_valid && (buf_word == word_idx);

  spw_lane_decode u_dec (
    .size(req_size), .ofs(req_addr[1:0]), .wdata(req_wdata),
    .lane_en(lane_en), .wdata_rep(wdata_rep)
  );

  spw_post_buffer #(.WIDX(WIDX)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_acc), .wr_word(word_idx),
    .wr_en(lane_en), .wr_data(wdata_rep), .valid(buf_valid),
    .buf_word(buf_word), .buf_en(buf_en), .buf_data(buf_data),
    .commit(commit_pulse)
  );

  spw_array #(.WORDS(WORDS), .WIDX(WIDX)) u_arr (
    .clk(clk), .we(commit_pulse), .waddr(buf_word), .wen(buf_en),
    .wdata(buf_data), .re(rd_acc), .raddr(word_idx), .rdata(arr_rdata)
  );

  spw_read_merge u_rd (
    .clk(clk), .rst_n(rst_n), .rd_accept(rd_acc), .rd_size(req_size),
    .rd_ofs(req_addr[1:0]), .hit(hit), .buf_en(buf_en), .buf_data(buf_data),
    .arr_rdata(arr_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  AST_COMMIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (req_valid && req_write)); // R6
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R9
  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rst_n)) |-> $past(req_valid && !req_write)); // R9
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd0) |=> (rsp_rdata[31:8] == 24'd0)); // R9
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |-> ($countones(lane_en) == 1)); // R3
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd1) |-> ($countones(lane_en) == 2)); // R3
endmodule

// File: tb/sram_posted_ctrl_tb.sv
module sram_posted_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int NV = 17;

  // {write, size, addr[15:0], wdata, expected read data}
  localparam logic [82:0] VEC [NV] = '{
    {1'b1, 2'd2, 16'h0010, 32'h11223344, 32'h0},        // R1 word write
    {1'b1, 2'd2, 16'h0014, 32'hAABBCCDD, 32'h0},        // R1 back-to-back
    {1'b0, 2'd2, 16'h0010, 32'h0, 32'h11223344},        // R6 committed
    {1'b0, 2'd2, 16'h0017, 32'h0, 32'hAABBCCDD},        // R2 R10 misaligned, forwarded
    {1'b1, 2'd0, 16'h0012, 32'h123456EE, 32'h0},        // R4 junk upper bits
    {1'b0, 2'd2, 16'h0010, 32'h0, 32'h11EE3344},        // R10 merge lane 2
    {1'b0, 2'd0, 16'h0012, 32'h0, 32'h000000EE},        // R3 byte lane
    {1'b0, 2'd1, 16'h0013, 32'h0, 32'h000011EE},        // R2 half ignores bit 0
    {1'b1, 2'd1, 16'h0015, 32'hFFFF5566, 32'h0},        // R4 half low lanes
    {1'b0, 2'd2, 16'h0014, 32'h0, 32'hAABB5566},        // R10 half merge
    {1'b0, 2'd0, 16'h0011, 32'h0, 32'h00000033},        // R3 byte from array
    {1'b1, 2'd2, 16'h0010, 32'hDEADBEEF, 32'h0},
    {1'b0, 2'd2, 16'h0014, 32'h0, 32'hAABB5566},        // R6 half committed
    {1'b0, 2'd1, 16'h0012, 32'h0, 32'h0000DEAD},        // R3 high half forwarded
    {1'b1, 2'd0, 16'h0017, 32'h00000077, 32'h0},
    {1'b0, 2'd2, 16'h0014, 32'h0, 32'h77BB5566},        // R10 lane 3
    {1'b0, 2'd0, 16'h0010, 32'h0, 32'h000000EF}         // R9 zero-extended
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, buf_valid, commit_pulse;
  logic [31:0]   rsp_rdata;
  int            errors = 0, checks = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_posted_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .buf_valid(buf_valid), .commit_pulse(commit_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with read data checked
  task automatic op(input bit wr, input logic [1:0] sz, input logic [15:0] a,
                    input logic [31:0] d, input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = a[AW-1:0]; req_wdata = d;
    #1 chk({tag, " R1 ready"}, {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    if (!wr) begin
      chk({tag, " R9 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
      chk(tag, rsp_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R5 buf_valid after reset", {31'd0, buf_valid}, 32'd0);
    chk("R9 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);

    // first write after reset: nothing to commit
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_addr = 11'h010; req_wdata = 32'h0;
    #1 chk("R6 no commit on first write", {31'd0, commit_pulse}, 32'd0);
    @(negedge clk);
    chk("R5 buf_valid after first write", {31'd0, buf_valid}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][82], VEC[i][81:80], VEC[i][79:64], VEC[i][63:32], VEC[i][31:0],
         $sformatf("vec%0d", i));
    end

    idle(1);
    chk("R9 single-cycle rsp", {31'd0, rsp_valid}, 32'd0);

    // R6: commit only with a new write
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_addr = 11'h020; req_wdata = 32'hCAFEF00D;
    #1 chk("R6 commit on write", {31'd0, commit_pulse}, 32'd1);
    @(negedge clk);
    op(1'b1, 2'd2, 16'h0024, 32'h01020304, 32'h0, "R6 w2");
    op(1'b1, 2'd2, 16'h0020, 32'h55555555, 32'h0, "R7 w3");
    req_valid = 1'b0;
    #1 chk("R6 no commit when idle", {31'd0, commit_pulse}, 32'd0);
    idle(5);
    op(1'b0, 2'd2, 16'h0024, 32'h0, 32'h01020304, "R6 read other word");
    req_valid = 1'b0;
    #1 chk("R6 no commit on read", {31'd0, commit_pulse}, 32'd0);
    @(negedge clk);
    do_reset();
    chk("R7 buf_valid cleared", {31'd0, buf_valid}, 32'd0);
    op(1'b0, 2'd2, 16'h0020, 32'h0, 32'hCAFEF00D, "R7 last write lost");

    // R8: identical pair survives reset
    op(1'b1, 2'd2, 16'h0028, 32'h0BADCAFE, 32'h0, "R8 w1");
    op(1'b1, 2'd2, 16'h0028, 32'h0BADCAFE, 32'h0, "R8 w2");
    idle(1);
    do_reset();
    op(1'b0, 2'd2, 16'h0028, 32'h0, 32'h0BADCAFE, "R8 persisted");
    idle(1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule